// File: doc/BRIEF.md
# Multiframe Context Register File

This block is the register file of a processor core that runs several threads in blocks. It keeps four hardware context frames on chip. Each frame has eight 32-bit general registers and its own program counter. A frame pointer chooses the active frame. The pipeline reads two registers and writes one, and all three go to whichever frame is active.

When a thread stalls on a cache miss or on a synchronization fault, the pipeline raises a switch request with a cause code. On the next clock edge the frame pointer moves to the next frame, in round-robin order, whose ready bit is set. No registers are copied. If no frame is ready, the block keeps the current frame and raises an idle flag. The pipeline can also ask for a particular context by its ID. When a frame holds that context, the pointer jumps to that frame. When no frame holds it, the block raises a one-cycle trap that carries the requested ID. Software then unloads a frame and loads the context, and it labels the active frame with its new context ID through a bind input.

Top module: `ctx_regfile`

## Requirements
- R1: Register index 0 of every frame always reads as zero, and writes to index 0 have no effect.
- R2: Both read ports return the addressed register of the active frame combinationally. A write with `wr_en` high lands in the active frame at the clock edge and is visible to reads from the next cycle. Other frames are not changed.
- R3: A switch request is accepted only when `sw_cause` is 2'b01 (cache miss) or 2'b10 (synchronization fault). Cause codes 2'b00 and 2'b11 leave the frame pointer unchanged.
- R4: An accepted switch changes `cur_frame` at the clock edge that ends the request cycle. Reads made during the request cycle still see the old frame.
- R5: An accepted switch moves the frame pointer to the first frame after the current one, counting upward modulo 4, whose `ready_mask` bit is set (bit i belongs to frame i). When only the current frame is ready, the pointer stays where it is.
- R6: `idle` is high exactly when `ready_mask` is all zero. A switch request made while idle leaves the frame pointer unchanged.
- R7: `active_pc` is the program counter of the active frame. `pc_wr_en` updates only that frame's counter, and a switch brings the new frame's stored counter to `active_pc`.
- R8: When `ctx_req` is high and a frame holds context `ctx_req_id`, the frame pointer moves to that frame on the next edge and no trap is raised. If several frames hold the ID, the lowest-numbered one is chosen.
- R9: When `ctx_req` is high and no frame holds `ctx_req_id`, `trap` is high for the next cycle, `trap_ctx` holds the requested ID, and the frame pointer does not move.
- R10: After reset, frame i holds context ID i. `bind_en` relabels the active frame with `bind_ctx` from the next cycle on, and `cur_ctx` shows the label of the active frame.
- R11: When `ctx_req` and an accepted switch request arrive in the same cycle, `ctx_req` decides the next frame.
- R12: Reset leaves frame 0 active with `trap` low, all registers and program counters at zero, and `trap_ctx` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_a_idx | input | 3 | Register index for read port A |
| rd_a_data | output | 32 | Read port A data from the active frame |
| rd_b_idx | input | 3 | Register index for read port B |
| rd_b_data | output | 32 | Read port B data from the active frame |
| wr_en | input | 1 | Write enable for the active frame |
| wr_idx | input | 3 | Register index to write |
| wr_data | input | 32 | Write data |
| pc_wr_en | input | 1 | Update the program counter of the active frame |
| pc_wr_data | input | 32 | New program counter value |
| active_pc | output | 32 | Program counter of the active frame |
| sw_req | input | 1 | Switch request from the pipeline |
| sw_cause | input | 2 | Switch cause: 01 miss, 10 sync fault, others ignored |
| ready_mask | input | 4 | Per-frame ready bits, bit i for frame i |
| ctx_req | input | 1 | Request for a specific context ID |
| ctx_req_id | input | 4 | Requested context ID |
| bind_en | input | 1 | Relabel the active frame |
| bind_ctx | input | 4 | New context ID for the active frame |
| cur_frame | output | 2 | Active frame number |
| cur_ctx | output | 4 | Context ID held by the active frame |
| trap | output | 1 | One-cycle pulse: requested context is not resident |
| trap_ctx | output | 4 | Context ID that caused the last trap |
| idle | output | 1 | No frame is ready |

## Verification
The bench builds the block with its default parameters: four frames of eight 32-bit registers and 4-bit context IDs. With four frames, a few steps of the round-robin search wrap past frame 3 and also reach the case where only the current frame is ready. With 4-bit IDs, the bench can ask for contexts 4 to 15, which no frame holds after reset, so it reaches the trap path. Rebinding a frame then shows that a context becomes resident and that the ID it replaced stops being resident.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_MISS = 2'b01,
    CAUSE_SYNC = 2'b10,
    CAUSE_RSVD = 2'b11
  } cause_e;

  function automatic logic cause_accepted(input logic [1:0] c);
    return (cause_e'(c) == CAUSE_MISS) || (cause_e'(c) == CAUSE_SYNC);
  endfunction
endpackage

// File: rtl/ctxrf_frames.sv
module ctxrf_frames #(
  parameter int NUM_FRAMES = 4,
  parameter int NUM_REGS   = 8,
  parameter int DATA_W     = 32,
  parameter int PC_W       = 32,
  localparam int FP_W      = $clog2(NUM_FRAMES),
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FP_W-1:0]   fp,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_wr_en,
  input  logic [PC_W-1:0]   pc_wr_data,
  output logic [PC_W-1:0]   active_pc
);
  // Index 0 has no storage; entry r-1 holds register r.
  logic [DATA_W-1:0] regs_q [NUM_FRAMES][NUM_REGS-1];
  logic [PC_W-1:0]   pc_q   [NUM_FRAMES];

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic frame_sel;
    assign frame_sel = (fp == FP_W'(f));

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
      logic reg_en;
      assign reg_en = wr_en && frame_sel && (wr_idx == IDX_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      regs_q[f][r-1] <= '0;
        else if (reg_en) regs_q[f][r-1] <= wr_data;
      end
    end

    logic pc_en;
    assign pc_en = pc_wr_en && frame_sel;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q[f] <= '0;
      else if (pc_en) pc_q[f] <= pc_wr_data;
    end
  end

  always_comb begin
    rd_a_data = (rd_a_idx == '0) ? '0 : regs_q[fp][rd_a_idx - 1'b1];
    rd_b_data = (rd_b_idx == '0) ? '0 : regs_q[fp][rd_b_idx - 1'b1];
    active_pc = pc_q[fp];
  end
endmodule

// File: rtl/ctxrf_sched.sv
module ctxrf_sched #(
  parameter int NUM_FRAMES = 4,
  localparam int FP_W      = $clog2(NUM_FRAMES)
) (
  input  logic [FP_W-1:0]       fp,
  input  logic [NUM_FRAMES-1:0] ready_mask,
  output logic [FP_W-1:0]       rr_next,
  output logic                  any_ready
);
  logic [FP_W-1:0] cand;
  logic            found;

  // Search upward from fp+1; the last step (k = NUM_FRAMES) is fp itself.
  always_comb begin
    rr_next = fp;
    found   = 1'b0;
    cand    = '0;
    for (int k = 1; k <= NUM_FRAMES; k++) begin
      cand = FP_W'((int'(fp) + k) % NUM_FRAMES);
      if (!found && ready_mask[cand]) begin
        rr_next = cand;
        found   = 1'b1;
      end
    end
    any_ready = |ready_mask;
  end
endmodule

// File: rtl/ctxrf_tags.sv
module ctxrf_tags #(
  parameter int NUM_FRAMES = 4,
  parameter int CTX_W      = 4,
  localparam int FP_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FP_W-1:0]  fp,
  input  logic             bind_en,
  input  logic [CTX_W-1:0] bind_ctx,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             hit,
  output logic [FP_W-1:0]  hit_frame,
  output logic [CTX_W-1:0] cur_ctx
);
  logic [CTX_W-1:0] tag_q [NUM_FRAMES];

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_tag
    logic tag_en;
    assign tag_en = bind_en && (fp == FP_W'(f));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q[f] <= CTX_W'(f);
      else if (tag_en) tag_q[f] <= bind_ctx;
    end
  end

  always_comb begin
    hit       = 1'b0;
    hit_frame = '0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (!hit && tag_q[f] == req_ctx) begin
        hit       = 1'b1;
        hit_frame = FP_W'(f);
      end
    end
    cur_ctx = tag_q[fp];
  end
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int NUM_FRAMES = 4,
  parameter int NUM_REGS   = 8,
  parameter int DATA_W     = 32,
  parameter int PC_W       = 32,
  parameter int CTX_W      = 4,
  localparam int FP_W      = $clog2(NUM_FRAMES),
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      rd_a_idx,
  output logic [DATA_W-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]      rd_b_idx,
  output logic [DATA_W-1:0]     rd_b_data,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  pc_wr_en,
  input  logic [PC_W-1:0]       pc_wr_data,
  output logic [PC_W-1:0]       active_pc,
  input  logic                  sw_req,
  input  logic [1:0]            sw_cause,
  input  logic [NUM_FRAMES-1:0] ready_mask,
  input  logic                  ctx_req,
  input  logic [CTX_W-1:0]      ctx_req_id,
  input  logic                  bind_en,
  input  logic [CTX_W-1:0]      bind_ctx,
  output logic [FP_W-1:0]       cur_frame,
  output logic [CTX_W-1:0]      cur_ctx,
  output logic                  trap,
  output logic [CTX_W-1:0]      trap_ctx,
  output logic                  idle
);
  import ctxrf_pkg::*;

  logic [FP_W-1:0]  fp_q, fp_d;
  logic             trap_q, trap_d;
  logic [CTX_W-1:0] trap_ctx_q, trap_ctx_d;
  logic [FP_W-1:0]  rr_next, hit_frame;
  logic             any_ready, hit, sw_valid;

  ctxrf_frames #(
    .NUM_FRAMES(NUM_FRAMES), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W)
  ) u_frames (
    .clk(clk), .rst_n(rst_n), .fp(fp_q),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .active_pc(active_pc)
  );

  ctxrf_sched #(.NUM_FRAMES(NUM_FRAMES)) u_sched (
    .fp(fp_q), .ready_mask(ready_mask), .rr_next(rr_next), .any_ready(any_ready)
  );

  ctxrf_tags #(.NUM_FRAMES(NUM_FRAMES), .CTX_W(CTX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .fp(fp_q),
    .bind_en(bind_en), .bind_ctx(bind_ctx), .req_ctx(ctx_req_id),
    .hit(hit), .hit_frame(hit_frame), .cur_ctx(cur_ctx)
  );

  assign sw_valid = sw_req && cause_accepted(sw_cause);

  // Next-state: an explicit context request wins over a stall switch.
  always_comb begin
    fp_d       = fp_q;
    trap_d     = 1'b0;
    trap_ctx_d = trap_ctx_q;
    if (ctx_req) begin
      if (hit) begin
        fp_d = hit_frame;
      end else begin
        trap_d     = 1'b1;
        trap_ctx_d = ctx_req_id;
      end
    end else if (sw_valid && any_ready) begin
      fp_d = rr_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q       <= '0;
      trap_q     <= 1'b0;
      trap_ctx_q <= '0;
    end else begin
      fp_q       <= fp_d;
      trap_q     <= trap_d;
      trap_ctx_q <= trap_ctx_d;
    end
  end

  assign cur_frame = fp_q;
  assign trap      = trap_q;
  assign trap_ctx  = trap_ctx_q;
  assign idle      = !any_ready;
endmodule

// File: rtl/ctxrf_chk.sv
module ctxrf_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 3,
  localparam int FP_W      = $clog2(NUM_FRAMES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [IDX_W-1:0]      rd_a_idx,
  input logic [DATA_W-1:0]     rd_a_data,
  input logic                  sw_req,
  input logic [1:0]            sw_cause,
  input logic [NUM_FRAMES-1:0] ready_mask,
  input logic                  ctx_req,
  input logic [FP_W-1:0]       cur_frame,
  input logic                  trap,
  input logic                  idle
);
  logic                  sw_ok;
  logic [NUM_FRAMES-1:0] prev_ready;

  assign sw_ok = sw_req && (sw_cause == 2'b01 || sw_cause == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ready <= '0;
    else        prev_ready <= ready_mask;
  end

  // R1
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  // R3
  no_spurious_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_req && !sw_ok) |=> $stable(cur_frame));

  // R5
  lands_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_req && sw_ok && |ready_mask) |=> prev_ready[cur_frame]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_req && idle) |=> $stable(cur_frame));

  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $stable(cur_frame));
endmodule

bind ctx_regfile ctxrf_chk #(
  .NUM_FRAMES(NUM_FRAMES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .sw_req(sw_req), .sw_cause(sw_cause), .ready_mask(ready_mask),
  .ctx_req(ctx_req), .cur_frame(cur_frame), .trap(trap), .idle(idle)
);

// File: tb/test_ctx_regfile.sv
module test_ctx_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_wr_data, active_pc;
  logic        wr_en, pc_wr_en, sw_req, ctx_req, bind_en, trap, idle;
  logic [1:0]  sw_cause, cur_frame;
  logic [3:0]  ready_mask, ctx_req_id, bind_ctx, cur_ctx, trap_ctx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  ctx_regfile i_ctx_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .active_pc(active_pc),
    .sw_req(sw_req), .sw_cause(sw_cause), .ready_mask(ready_mask),
    .ctx_req(ctx_req), .ctx_req_id(ctx_req_id),
    .bind_en(bind_en), .bind_ctx(bind_ctx),
    .cur_frame(cur_frame), .cur_ctx(cur_ctx),
    .trap(trap), .trap_ctx(trap_ctx), .idle(idle)
  );

  // {ready_mask[3:0], sw_cause[1:0], expected frame[1:0]}, start at frame 0
  localparam logic [7:0] VEC [10] = '{
    {4'b1111, 2'b01, 2'd1},   // R5 step up
    {4'b1111, 2'b10, 2'd2},   // R3 sync fault accepted
    {4'b1111, 2'b00, 2'd2},   // R3 code 00 ignored
    {4'b1111, 2'b11, 2'd2},   // R3 code 11 ignored
    {4'b1011, 2'b01, 2'd3},   // R5
    {4'b1011, 2'b01, 2'd0},   // R5 wrap
    {4'b0001, 2'b01, 2'd0},   // R5 only current ready
    {4'b0100, 2'b01, 2'd2},   // R5 skip not-ready
    {4'b0000, 2'b01, 2'd2},   // R6 idle hold
    {4'b1111, 2'b10, 2'd3}    // R5
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    rd_a_idx = 3'd0; rd_b_idx = 3'd0; wr_idx = 3'd0; wr_data = '0; wr_en = 1'b0;
    pc_wr_en = 1'b0; pc_wr_data = '0; sw_req = 1'b0; sw_cause = 2'b00;
    ready_mask = 4'b1111; ctx_req = 1'b0; ctx_req_id = '0; bind_en = 1'b0; bind_ctx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 frame", 32'(cur_frame), 0);
    chk("R12 trap", 32'(trap), 0);
    chk("R12 trap_ctx", 32'(trap_ctx), 0);
    chk("R12 pc", active_pc, 0);
    rd_a_idx = 3'd5;
    #1 chk("R12 reg", rd_a_data, 0);
    chk("R10 reset tag", 32'(cur_ctx), 0);

    // Round-robin table
    for (int i = 0; i < 10; i++) begin
      ready_mask = VEC[i][7:4];
      sw_cause   = VEC[i][3:2];
      sw_req     = 1'b1;
      #1 chk("R6 idle", 32'(idle), 32'(VEC[i][7:4] == 4'b0000));
      step();
      sw_req = 1'b0;
      chk("R5/R3/R6 frame", 32'(cur_frame), 32'(VEC[i][1:0]));
    end
    ready_mask = 4'b1111;

    // R8 resident request: context 0 lives in frame 0
    ctx_req = 1'b1; ctx_req_id = 4'd0;
    step();
    ctx_req = 1'b0;
    chk("R8 frame", 32'(cur_frame), 0);
    chk("R8 no trap", 32'(trap), 0);

    // R2 / R1 writes
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 32'hA5A5_0003;
    step();
    wr_idx = 3'd0; wr_data = 32'hFFFF_FFFF;
    step();
    wr_en = 1'b0;
    rd_a_idx = 3'd3; rd_b_idx = 3'd0;
    #1 chk("R2 read", rd_a_data, 32'hA5A5_0003);
    chk("R1 reg0", rd_b_data, 0);

    // R7 pc write
    pc_wr_en = 1'b1; pc_wr_data = 32'h100;
    step();
    pc_wr_en = 1'b0;
    chk("R7 pc f0", active_pc, 32'h100);

    // R4 switch timing
    sw_req = 1'b1; sw_cause = 2'b01;
    #1 chk("R4 old frame read", rd_a_data, 32'hA5A5_0003);
    step();
    sw_req = 1'b0;
    chk("R4 frame", 32'(cur_frame), 1);
    chk("R2 isolation", rd_a_data, 0);
    chk("R7 pc f1", active_pc, 0);
    wr_en = 1'b1; wr_idx = 3'd3; wr_data = 32'h77;
    pc_wr_en = 1'b1; pc_wr_data = 32'h200;
    step();
    wr_en = 1'b0; pc_wr_en = 1'b0;
    chk("R2 f1 read", rd_a_data, 32'h77);
    sw_req = 1'b1; sw_cause = 2'b10;
    repeat (3) step();
    sw_req = 1'b0;
    chk("R5 wrap frame", 32'(cur_frame), 0);
    chk("R2 f0 kept", rd_a_data, 32'hA5A5_0003);
    chk("R7 pc f0 kept", active_pc, 32'h100);

    // R9 non-resident
    ctx_req = 1'b1; ctx_req_id = 4'd9;
    step();
    ctx_req = 1'b0;
    chk("R9 trap", 32'(trap), 1);
    chk("R9 trap_ctx", 32'(trap_ctx), 9);
    chk("R9 frame", 32'(cur_frame), 0);
    step();
    chk("R9 pulse", 32'(trap), 0);

    // R10 bind
    ctx_req = 1'b1; ctx_req_id = 4'd2;
    step();
    ctx_req = 1'b0;
    chk("R8 frame2", 32'(cur_frame), 2);
    bind_en = 1'b1; bind_ctx = 4'd9;
    step();
    bind_en = 1'b0;
    chk("R10 cur_ctx", 32'(cur_ctx), 9);
    ctx_req = 1'b1; ctx_req_id = 4'd0;
    step();
    ctx_req_id = 4'd9;
    step();
    ctx_req = 1'b0;
    chk("R10 bound resident", 32'(cur_frame), 2);
    chk("R10 no trap", 32'(trap), 0);
    ctx_req = 1'b1; ctx_req_id = 4'd2;
    step();
    ctx_req = 1'b0;
    chk("R10 replaced id traps", 32'(trap), 1);
    chk("R10 frame held", 32'(cur_frame), 2);

    // R11 priority: sw alone would go to 3
    ctx_req = 1'b1; ctx_req_id = 4'd1; sw_req = 1'b1; sw_cause = 2'b01;
    step();
    ctx_req = 1'b0; sw_req = 1'b0;
    chk("R11 priority", 32'(cur_frame), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule